// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer with Reset Pulse

This block is a watchdog counter sitting behind a byte-wide configuration port. Software writes a nonzero value into the timeout register to arm it. That register is also the live down-counter, so reading it returns the time still left, and writing zero disarms the watchdog. Rewriting a nonzero value while the counter runs reloads it, and this is how software keeps the watchdog alive.

The counter steps once per unit. A unit is one pulse of the external one-second tick, or sixty such pulses when the control register selects minute units. When the count steps from one to zero, a sticky status flag is set and an active-low pulse of fixed length is driven out. The same pulse can also be routed to a keyboard-reset line. Keyboard and mouse activity can be enabled to reload the running counter with the last armed value.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, the timeout (0xF6), control (0xF5) and status (0xF7) registers all read 0x00. `wdt_n_o` and `kbrst_n_o` are high and `expired_o` is low.
- R2: A write of a nonzero value to 0xF6 loads the counter with that value. A read of 0xF6 returns the present remaining count.
- R3: In second units (control bit 3 clear), each `tick_i` cycle lowers a nonzero count by one. A count of zero stays at zero, ignores ticks and produces no pulse.
- R4: A write of zero to 0xF6 stops the counter. A nonzero write while running reloads the counter. A write in the same cycle as a tick takes priority over the tick.
- R5: With control bit 3 set (minute units), the count drops by one per 60 ticks. The tick prescaler restarts on every nonzero write to 0xF6.
- R6: The step from 1 to 0 sets status bit 4. It also drives `wdt_n_o` low for exactly 16 clock cycles, starting the cycle after the stepping edge.
- R7: `kbrst_n_o` copies `wdt_n_o` while control bit 1 is set. Otherwise it stays high.
- R8: Status bit 4 is cleared by writing 0x0 into it. Writing 1 there leaves it unchanged, and expiry in the same cycle wins over a clear. `expired_o` mirrors the bit.
- R9: While the counter is nonzero, a `kbd_evt_i` cycle reloads the last nonzero value written, if control bit 2 or status bit 7 is set. A `mouse_evt_i` cycle does the same if status bit 6 is set. Without enable, or with the counter at zero, these events have no effect.
- R10: The control register reads back the whole written byte. The status register reads bits 7, 6 and 4, with the other bits as 0. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register index for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| kbd_evt_i | input | 1 | Keyboard activity, one cycle per event |
| mouse_evt_i | input | 1 | Mouse activity, one cycle per event |
| wdt_n_o | output | 1 | Active-low timeout pulse |
| kbrst_n_o | output | 1 | Timeout pulse routed to keyboard reset, active low |
| expired_o | output | 1 | Sticky expiry status |

## Verification
Register writes, ticks and activity events act at the clock edge that samples them. Read data is combinational, so a new count is visible in the cycle after that edge. The bench drives on falling edges and reads half a cycle after the rising edge that took the stimulus. The expiry flag and the low level on `wdt_n_o` both show up one cycle after the final tick. The bench then counts the low cycles on later falling edges and expects exactly 16 before the line returns high.

// File: rtl/wdt_sec_pkg.sv
package wdt_sec_pkg;
  localparam logic [7:0] ADDR_TMO  = 8'hF6;
  localparam logic [7:0] ADDR_CTRL = 8'hF5;
  localparam logic [7:0] ADDR_STAT = 8'hF7;
  // control bits
  localparam int CTRL_KBRST = 1;
  localparam int CTRL_KBDRL = 2;
  localparam int CTRL_MIN   = 3;
  // status bits
  localparam int STAT_FLAG  = 4;
  localparam int STAT_MSRL  = 6;
  localparam int STAT_KBRL  = 7;
endpackage

// File: rtl/wdt_unit_pre.sv
module wdt_unit_pre #(
  parameter int DIV = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic minute_i,
  input  logic clear_i,
  output logic step_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clear_i)            pre_q <= '0;
    else if (tick_i && minute_i) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign step_o = tick_i && (!minute_i || pre_q == LAST);

  // R5
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         step_i,
  input  logic         reload_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, last_q;
  logic         run, do_rl;

  assign run   = cnt_q != '0;
  assign do_rl = reload_i && run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wr_val_i;
      if (wr_val_i != '0) last_q <= wr_val_i;
    end else if (do_rl) begin
      cnt_q <= last_q;
    end else if (step_i && run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = !wr_i && !do_rl && step_i && cnt_q == W'(1);

  // R3
  stay_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_i) |=> cnt_q == '0);
  // R3
  no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !reload_i) |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_n_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_n_o = (cnt_q == '0);

  // R6
  fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_n_o) |-> $past(start_i));
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import wdt_sec_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MIN_DIV   = 60,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             kbd_evt_i,
  input  logic             mouse_evt_i,
  output logic             wdt_n_o,
  output logic             kbrst_n_o,
  output logic             expired_o
);
  logic [7:0]       ctrl_q;
  logic             ms_en_q, kb_en_q, flag_q;
  logic             wr_tmo, wr_ctrl, wr_stat;
  logic             step, expire, reload, pulse_n;
  logic [CNT_W-1:0] cnt;

  assign wr_tmo  = reg_wr_i && reg_addr_i == ADDR_TMO;
  assign wr_ctrl = reg_wr_i && reg_addr_i == ADDR_CTRL;
  assign wr_stat = reg_wr_i && reg_addr_i == ADDR_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ms_en_q <= 1'b0;
      kb_en_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i;
      if (wr_stat) begin
        ms_en_q <= reg_wdata_i[STAT_MSRL];
        kb_en_q <= reg_wdata_i[STAT_KBRL];
      end
      if (expire)                                  flag_q <= 1'b1;
      else if (wr_stat && !reg_wdata_i[STAT_FLAG]) flag_q <= 1'b0;
    end
  end

  assign reload = (kbd_evt_i && (ctrl_q[CTRL_KBDRL] || kb_en_q))
               || (mouse_evt_i && ms_en_q);

  wdt_unit_pre #(.DIV(MIN_DIV)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .minute_i (ctrl_q[CTRL_MIN]),
    .clear_i  (wr_tmo && reg_wdata_i[CNT_W-1:0] != '0),
    .step_o   (step)
  );

  wdt_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_tmo),
    .wr_val_i (reg_wdata_i[CNT_W-1:0]),
    .step_i   (step),
    .reload_i (reload),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (expire),
    .pulse_n_o (pulse_n)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_TMO:  reg_rdata_o = 8'(cnt);
      ADDR_CTRL: reg_rdata_o = ctrl_q;
      ADDR_STAT: reg_rdata_o = {kb_en_q, ms_en_q, 1'b0, flag_q, 4'b0};
      default:   reg_rdata_o = 8'h00;
    endcase
  end

  assign wdt_n_o   = pulse_n;
  assign kbrst_n_o = pulse_n || !ctrl_q[CTRL_KBRST];
  assign expired_o = flag_q;

  // R6
  expire_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (expired_o && !wdt_n_o));
  // R7
  kbrst_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CTRL_KBRST] |-> kbrst_n_o);
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !wr_stat) |=> flag_q);
endmodule

// File: tb/sec_watchdog_tb.sv
module sec_watchdog_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0, kbd = 1'b0, ms = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       wdt_n, kbrst_n, expired;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sec_watchdog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .kbd_evt_i(kbd), .mouse_evt_i(ms), .wdt_n_o(wdt_n),
    .kbrst_n_o(kbrst_n), .expired_o(expired)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a; #0.5;
    chk(req, rdata, exp);
  endtask

  // op[17:16]: 0 write, 1 tick, 2 read-check; addr[15:8]; data[7:0]
  localparam int NV = 16;
  localparam logic [17:0] VECS [NV] = '{
    {2'd0, 8'hF6, 8'h03}, {2'd2, 8'hF6, 8'h03},
    {2'd1, 8'h00, 8'h00}, {2'd2, 8'hF6, 8'h02},
    {2'd0, 8'hF6, 8'h07}, {2'd2, 8'hF6, 8'h07},
    {2'd1, 8'h00, 8'h00}, {2'd2, 8'hF6, 8'h06},
    {2'd0, 8'hF6, 8'h00}, {2'd1, 8'h00, 8'h00},
    {2'd2, 8'hF6, 8'h00}, {2'd0, 8'hF5, 8'hA5},
    {2'd2, 8'hF5, 8'hA5}, {2'd2, 8'h30, 8'h00},
    {2'd0, 8'hF5, 8'h00}, {2'd2, 8'hF5, 8'h00}
  };

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1", 8'hF6, 8'h00); rd("R1", 8'hF5, 8'h00); rd("R1", 8'hF7, 8'h00);
    chk("R1", {wdt_n, kbrst_n, expired}, 3'b110);
    rst_n = 1'b1;

    // R2 R3 R4 R10 vector walk
    for (int v = 0; v < NV; v++) begin
      case (VECS[v][17:16])
        2'd0: wr_reg(VECS[v][15:8], VECS[v][7:0]);
        2'd1: do_tick();
        default: rd("R2/R3/R4/R10 vec", VECS[v][15:8], VECS[v][7:0]);
      endcase
    end

    // R3 stopped counter ignores ticks, no pulse
    ticks(3);
    rd("R3", 8'hF6, 8'h00);
    chk("R3", {wdt_n, expired}, 2'b10);

    // R4 write wins over same-cycle tick
    wr_reg(8'hF6, 8'h04);
    @(negedge clk); wr = 1'b1; addr = 8'hF6; wdata = 8'h09; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd("R4", 8'hF6, 8'h09);

    // R6 R7 expiry with keyboard-reset routing on
    wr_reg(8'hF5, 8'h02);
    wr_reg(8'hF6, 8'h02);
    do_tick();
    rd("R6", 8'hF6, 8'h01);
    chk("R6", wdt_n, 1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R6", {wdt_n, expired}, 2'b01);
    chk("R7", kbrst_n, 0);
    lows = 1;
    while (!wdt_n && lows < 40) begin @(negedge clk); if (!wdt_n) lows++; end
    chk("R6 low cycles", lows, 16);
    chk("R7", kbrst_n, 1);
    rd("R6/R10", 8'hF7, 8'h10);

    // R8 writing 1 keeps the flag, writing 0 clears it
    wr_reg(8'hF7, 8'h10);
    chk("R8", expired, 1);
    wr_reg(8'hF7, 8'h00);
    chk("R8", expired, 0);
    rd("R8", 8'hF7, 8'h00);

    // R7 routing off: kbrst stays high during pulse
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF6, 8'h01);
    do_tick();
    chk("R7", {wdt_n, kbrst_n}, 2'b01);
    repeat (20) @(negedge clk);
    wr_reg(8'hF7, 8'h00);

    // R9 reload sources
    wr_reg(8'hF6, 8'h05);
    ticks(2);
    @(negedge clk); kbd = 1'b1; @(negedge clk); kbd = 1'b0;
    rd("R9 kbd disabled", 8'hF6, 8'h03);
    @(negedge clk); ms = 1'b1; @(negedge clk); ms = 1'b0;
    rd("R9 mouse disabled", 8'hF6, 8'h03);
    wr_reg(8'hF5, 8'h04);
    @(negedge clk); kbd = 1'b1; @(negedge clk); kbd = 1'b0;
    rd("R9 kbd ctrl", 8'hF6, 8'h05);
    wr_reg(8'hF5, 8'h00);
    wr_reg(8'hF7, 8'h40);
    do_tick();
    @(negedge clk); ms = 1'b1; @(negedge clk); ms = 1'b0;
    rd("R9 mouse", 8'hF6, 8'h05);
    wr_reg(8'hF7, 8'h80);
    rd("R10", 8'hF7, 8'h80);
    do_tick();
    @(negedge clk); kbd = 1'b1; @(negedge clk); kbd = 1'b0;
    rd("R9 kbd stat", 8'hF6, 8'h05);
    wr_reg(8'hF6, 8'h00);
    @(negedge clk); kbd = 1'b1; @(negedge clk); kbd = 1'b0;
    rd("R9 stopped", 8'hF6, 8'h00);
    wr_reg(8'hF7, 8'h00);

    // R5 minute units
    wr_reg(8'hF5, 8'h08);
    wr_reg(8'hF6, 8'h02);
    ticks(59);
    rd("R5", 8'hF6, 8'h02);
    do_tick();
    rd("R5", 8'hF6, 8'h01);
    ticks(30);
    wr_reg(8'hF6, 8'h02);
    ticks(59);
    rd("R5 restart", 8'hF6, 8'h02);
    do_tick();
    rd("R5 restart", 8'hF6, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule